// File: doc/BRIEF.md
# I2C slave acknowledge command controller

This block is the software-facing control layer of an I2C slave. A bit-level byte engine next to it reports each address byte or data byte, together with the transfer direction, and then holds SCL low. The controller records which kind of event is pending and keeps the hold request asserted. It releases the hold only when the CPU tells it what to do next. The CPU can write a command into the command field of the second control register. With smart mode enabled, the CPU can instead simply read the data register.

On release the controller issues a one-cycle release pulse. Alongside it come an acknowledge-enable flag with the ACK/NACK value, and a wait-for-START request when the transaction is finished. The acknowledge bit is only driven for a byte the slave has just received: an address byte, or a data byte while the master writes. When the master reads, a completion only waits for the next START or repeated START. A response command in that case only frees the bus for the next transmit byte.

The CPU port has four byte-wide registers: control A, control B, data and status. Reads are combinational.

Top module: `i2c_tgt_ack_ctrl`

## Requirements
- R1: After reset, `stretch_hold`, `rel_pulse`, `ack_en`, `ack_nack` and `wait_start` are 0, and reads of all four registers return 0.
- R2: Control A (offset 0) keeps only bit 0, the smart-mode enable. Its other bits read 0. Control B (offset 1) keeps only bit 2, the acknowledge select (0 = ACK, 1 = NACK). Its command field in bits 1:0 and bits 7:3 always read 0.
- R3: An address event or a data event sets its pending flag and raises `stretch_hold` after the next clock edge. The status register (offset 3) then shows the data flag in bit 0, the address flag in bit 1 and the latched direction in bit 2 (1 = master reads). The data register (offset 2) returns the byte latched with the event.
- R4: Command 2'b10 (complete), written while a received byte is pending, produces the following in the cycle after the write, for exactly one cycle: `rel_pulse`, `ack_en`, `wait_start`, and `ack_nack` equal to the written bit 2. A received byte is a pending address event, or a data event with direction 0. `stretch_hold` drops in that same cycle.
- R5: Command 2'b10, written while a data event with direction 1 is pending, gives `rel_pulse` and `wait_start` with `ack_en` = `ack_nack` = 0.
- R6: Command 2'b11 (respond), written while a received byte is pending, gives `rel_pulse`, `ack_en`, and `ack_nack` equal to the written bit 2, with `wait_start` = 0.
- R7: Command 2'b11, written while a data event with direction 1 is pending, gives `rel_pulse` only. `ack_en`, `ack_nack` and `wait_start` stay 0.
- R8: Command 2'b00, the reserved command 2'b01, and any command written while nothing is pending produce no pulse on any output. The pending flags and `stretch_hold` are left unchanged, while bit 2 of control B is still stored.
- R9: With smart mode on, a read of the data register while a received byte is pending gives, in the next cycle, `rel_pulse` and `ack_en` with `ack_nack` equal to the stored acknowledge select, and `wait_start` = 0.
- R10: A data-register read has no effect when smart mode is off. It also has no effect in smart mode while a data event with direction 1 is pending.
- R11: An event that arrives in the same cycle as a release leaves its own flag pending and `stretch_hold` high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | CPU register write strobe |
| reg_rd_en | input | 1 | CPU register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid in the cycle of `reg_rd_en` |
| eng_addr_evt | input | 1 | Engine pulse: address byte received |
| eng_data_evt | input | 1 | Engine pulse: data byte received or transmit slot reached |
| eng_dir | input | 1 | Direction with the event, 1 = master reads |
| eng_byte | input | REG_W | Byte latched with the event |
| stretch_hold | output | 1 | Keep SCL low while an event is pending |
| rel_pulse | output | 1 | One-cycle stretch release |
| ack_en | output | 1 | Drive the acknowledge bit with this release |
| ack_nack | output | 1 | Acknowledge value, 1 = NACK |
| wait_start | output | 1 | Idle until the next START or repeated START |

## Verification
The bench sweeps every command code against both directions, both event kinds, both acknowledge selects and both trigger paths. A design that drove the acknowledge during a master-read completion would pull SDA while the master owns it. A design that released on the reserved code would let the bus run while the CPU believes it still holds it. Smart-mode reads during a transmit slot are tried, because releasing there would send a byte the CPU never loaded. An event that lands in the very cycle of a release is also tried: if clear won over set, that byte would go unanswered and the bus would stall.

// File: rtl/i2c_tgt_ack_pkg.sv
// Package: shared command codes, register offsets, bit positions and the
// response bundle used by the acknowledge command controller.
package i2c_tgt_ack_pkg;

    // Command field codes written into control B bits 1:0.
    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_RSVD = 2'b01,
        CMD_DONE = 2'b10,
        CMD_RESP = 2'b11
    } cmd_e;

    // One release decision, registered and sent to the byte engine.
    typedef struct packed {
        logic rel;
        logic ack_en;
        logic nack;
        logic wait_s;
    } resp_t;

    // Register offsets on the CPU port.
    localparam int OFS_CTRLA = 0;
    localparam int OFS_CTRLB = 1;
    localparam int OFS_DATA  = 2;
    localparam int OFS_STAT  = 3;

    // Bit positions inside the registers.
    localparam int SMEN_BIT   = 0;
    localparam int ACKSEL_BIT = 2;
    localparam int CMD_LSB    = 0;
    localparam int CMD_W      = 2;
    localparam int STAT_DATA  = 0;
    localparam int STAT_ADDR  = 1;
    localparam int STAT_DIR   = 2;

endpackage

// File: rtl/i2c_tgt_ack_regs.sv
// Register block: holds the smart-mode enable and the acknowledge select,
// decodes command writes into a strobe and produces the combinational read
// mux. Assumes one CPU access per cycle; when write and read are both
// asserted, the read is not treated as a data-register read trigger.
module i2c_tgt_ack_regs
    import i2c_tgt_ack_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  byte_q,
    input  logic              data_pend,
    input  logic              addr_pend,
    input  logic              dir_q,
    output logic [REG_W-1:0]  rdata,
    output logic              smen,
    output logic              ack_sel,
    output logic              cmd_stb,
    output cmd_e              cmd,
    output logic              cmd_ack_sel,
    output logic              data_rd_stb
);

    localparam logic [ADDR_W-1:0] A_CTRLA = ADDR_W'(OFS_CTRLA);
    localparam logic [ADDR_W-1:0] A_CTRLB = ADDR_W'(OFS_CTRLB);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    logic smen_q;
    logic ack_sel_q;
    logic ctrla_wr;
    logic ctrlb_wr;
    logic unused_wdata_bits;

    assign ctrla_wr = wr_en && (addr == A_CTRLA);
    assign ctrlb_wr = wr_en && (addr == A_CTRLB);
    assign unused_wdata_bits = ^wdata;

    // Store the configuration bits; reserved bits are not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smen_q    <= 1'b0;
            ack_sel_q <= 1'b0;
        end else begin
            if (ctrla_wr) smen_q    <= wdata[SMEN_BIT];
            if (ctrlb_wr) ack_sel_q <= wdata[ACKSEL_BIT];
        end
    end

    // Command strobe and its acknowledge select come straight from the write.
    always_comb begin
        cmd_stb     = ctrlb_wr;
        cmd         = cmd_e'(wdata[CMD_LSB +: CMD_W]);
        cmd_ack_sel = wdata[ACKSEL_BIT];
        data_rd_stb = rd_en && !wr_en && (addr == A_DATA);
    end

    assign smen    = smen_q;
    assign ack_sel = ack_sel_q;

    // Read mux; command bits and reserved bits always return zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTRLA: rdata[SMEN_BIT]   = smen_q;
                A_CTRLB: rdata[ACKSEL_BIT] = ack_sel_q;
                A_DATA:  rdata             = byte_q;
                A_STAT: begin
                    rdata[STAT_DATA] = data_pend;
                    rdata[STAT_ADDR] = addr_pend;
                    rdata[STAT_DIR]  = dir_q;
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/i2c_tgt_ack_evt.sv
// Event tracker: latches which engine event is pending, its direction and
// its byte. A new event wins over a clear in the same cycle so that no
// event is lost. Assumes the engine never raises both events together;
// if it does, the address event takes precedence.
module i2c_tgt_ack_evt #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_evt,
    input  logic             data_evt,
    input  logic             dir_in,
    input  logic [REG_W-1:0] byte_in,
    input  logic             clr,
    output logic             addr_pend,
    output logic             data_pend,
    output logic             dir_q,
    output logic [REG_W-1:0] byte_q
);

    // Pending flags: set by events, cleared by a release, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_pend <= 1'b0;
            data_pend <= 1'b0;
        end else if (addr_evt) begin
            addr_pend <= 1'b1;
            data_pend <= 1'b0;
        end else if (data_evt) begin
            addr_pend <= 1'b0;
            data_pend <= 1'b1;
        end else if (clr) begin
            addr_pend <= 1'b0;
            data_pend <= 1'b0;
        end
    end

    // Capture the direction and the byte with each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            byte_q <= '0;
        end else if (addr_evt || data_evt) begin
            dir_q  <= dir_in;
            byte_q <= byte_in;
        end
    end

endmodule

// File: rtl/i2c_tgt_ack_resp.sv
// Response decoder: turns a command strobe or a smart-mode data read into
// a registered release bundle for the byte engine. The acknowledge is only
// requested when the pending event is a byte the slave received.
module i2c_tgt_ack_resp
    import i2c_tgt_ack_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_stb,
    input  cmd_e  cmd,
    input  logic  cmd_ack_sel,
    input  logic  data_rd_stb,
    input  logic  smen,
    input  logic  ack_sel,
    input  logic  addr_pend,
    input  logic  data_pend,
    input  logic  dir_q,
    output resp_t resp_q,
    output logic  clr
);

    logic  pend;
    logic  rx_case;
    logic  cmd_go;
    logic  smart_go;
    resp_t resp_d;

    // Classify the pending event and decide whether this access releases.
    always_comb begin
        pend     = addr_pend || data_pend;
        rx_case  = addr_pend || (data_pend && !dir_q);
        cmd_go   = cmd_stb && pend && ((cmd == CMD_DONE) || (cmd == CMD_RESP));
        smart_go = smen && data_rd_stb && pend && rx_case;
    end

    // Build the release bundle for the next cycle.
    always_comb begin
        resp_d        = '0;
        resp_d.rel    = cmd_go || smart_go;
        resp_d.ack_en = (cmd_go || smart_go) && rx_case;
        resp_d.nack   = resp_d.ack_en && (cmd_go ? cmd_ack_sel : ack_sel);
        resp_d.wait_s = cmd_go && (cmd == CMD_DONE);
        clr           = resp_d.rel;
    end

    // Register the bundle so every output is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

endmodule

// File: rtl/i2c_tgt_ack_ctrl.sv
// Top: I2C slave acknowledge command controller. Connects the register
// block, the event tracker and the response decoder. Assumes the engine
// holds SCL for as long as stretch_hold is high and acts on rel_pulse.
module i2c_tgt_ack_ctrl
    import i2c_tgt_ack_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_addr_evt,
    input  logic              eng_data_evt,
    input  logic              eng_dir,
    input  logic [REG_W-1:0]  eng_byte,
    output logic              stretch_hold,
    output logic              rel_pulse,
    output logic              ack_en,
    output logic              ack_nack,
    output logic              wait_start
);

    logic             smen;
    logic             ack_sel;
    logic             cmd_stb;
    cmd_e             cmd;
    logic             cmd_ack_sel;
    logic             data_rd_stb;
    logic             addr_pend;
    logic             data_pend;
    logic             dir_q;
    logic [REG_W-1:0] byte_q;
    logic             clr;
    resp_t            resp_q;

    i2c_tgt_ack_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .rd_en       (reg_rd_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .byte_q      (byte_q),
        .data_pend   (data_pend),
        .addr_pend   (addr_pend),
        .dir_q       (dir_q),
        .rdata       (reg_rdata),
        .smen        (smen),
        .ack_sel     (ack_sel),
        .cmd_stb     (cmd_stb),
        .cmd         (cmd),
        .cmd_ack_sel (cmd_ack_sel),
        .data_rd_stb (data_rd_stb)
    );

    i2c_tgt_ack_evt #(.REG_W(REG_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_evt  (eng_addr_evt),
        .data_evt  (eng_data_evt),
        .dir_in    (eng_dir),
        .byte_in   (eng_byte),
        .clr       (clr),
        .addr_pend (addr_pend),
        .data_pend (data_pend),
        .dir_q     (dir_q),
        .byte_q    (byte_q)
    );

    i2c_tgt_ack_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_stb     (cmd_stb),
        .cmd         (cmd),
        .cmd_ack_sel (cmd_ack_sel),
        .data_rd_stb (data_rd_stb),
        .smen        (smen),
        .ack_sel     (ack_sel),
        .addr_pend   (addr_pend),
        .data_pend   (data_pend),
        .dir_q       (dir_q),
        .resp_q      (resp_q),
        .clr         (clr)
    );

    // Drive the engine-facing outputs from the flags and the release bundle.
    always_comb begin
        stretch_hold = addr_pend || data_pend;
        rel_pulse    = resp_q.rel;
        ack_en       = resp_q.ack_en;
        ack_nack     = resp_q.nack;
        wait_start   = resp_q.wait_s;
    end

endmodule

// File: rtl/i2c_tgt_ack_ctrl_chk.sv
// Checker: port-level properties of the acknowledge command controller,
// bound to every instance of the top module.
module i2c_tgt_ack_ctrl_chk
    import i2c_tgt_ack_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              eng_addr_evt,
    input logic              eng_data_evt,
    input logic              stretch_hold,
    input logic              rel_pulse,
    input logic              ack_en,
    input logic              ack_nack,
    input logic              wait_start
);

    localparam logic [REG_W-1:0] CTRLB_KEEP = REG_W'(1) << ACKSEL_BIT;
    localparam logic [ADDR_W-1:0] A_CTRLB   = ADDR_W'(OFS_CTRLB);

    // R4 R6 R9: acknowledge is only driven together with a release
    assert_ack_in_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |-> rel_pulse);

    // R6: a NACK value is only presented when the acknowledge is driven
    assert_nack_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nack |-> ack_en);

    // R5: wait-for-START only accompanies a release
    assert_wait_in_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_start |-> rel_pulse);

    // R8: no release unless an event was holding the bus
    assert_release_needs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pulse |-> $past(stretch_hold));

    // R8 R10: a release always follows a CPU access
    assert_release_needs_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pulse |-> ($past(reg_wr_en) || $past(reg_rd_en)));

    // R2: control B command and reserved bits read as zero
    assert_ctrlb_strobe_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_addr == A_CTRLB) |-> ((reg_rdata & ~CTRLB_KEEP) == '0));

    // R3 R11: every event leaves the bus held afterwards
    assert_hold_after_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_addr_evt || eng_data_evt) |=> stretch_hold);

endmodule

bind i2c_tgt_ack_ctrl i2c_tgt_ack_ctrl_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .eng_addr_evt (eng_addr_evt),
    .eng_data_evt (eng_data_evt),
    .stretch_hold (stretch_hold),
    .rel_pulse    (rel_pulse),
    .ack_en       (ack_en),
    .ack_nack     (ack_nack),
    .wait_start   (wait_start)
);

// File: tb/i2c_tgt_ack_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for the acknowledge command controller.
module i2c_tgt_ack_ctrl_tb;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRLA = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRLB = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic              reg_rd_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              eng_addr_evt = 1'b0;
    logic              eng_data_evt = 1'b0;
    logic              eng_dir = 1'b0;
    logic [REG_W-1:0]  eng_byte = '0;
    logic              stretch_hold;
    logic              rel_pulse;
    logic              ack_en;
    logic              ack_nack;
    logic              wait_start;

    int n_chk = 0;
    int n_fail = 0;
    logic [REG_W-1:0] rd_val;

    always #10 clk = ~clk;

    i2c_tgt_ack_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_addr_evt(eng_addr_evt), .eng_data_evt(eng_data_evt), .eng_dir(eng_dir),
        .eng_byte(eng_byte), .stretch_hold(stretch_hold), .rel_pulse(rel_pulse),
        .ack_en(ack_en), .ack_nack(ack_nack), .wait_start(wait_start)
    );

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Compare all engine-facing outputs at once.
    task automatic chk_out(input bit h, input bit r, input bit a, input bit n,
                           input bit w, input string req);
        chk(stretch_hold, h, {req, " stretch_hold"});
        chk(rel_pulse,    r, {req, " rel_pulse"});
        chk(ack_en,       a, {req, " ack_en"});
        chk(ack_nack,     n, {req, " ack_nack"});
        chk(wait_start,   w, {req, " wait_start"});
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic evt(input bit is_addr, input bit dir, input logic [REG_W-1:0] b);
        eng_addr_evt = is_addr; eng_data_evt = !is_addr; eng_dir = dir; eng_byte = b;
        @(negedge clk);
        eng_addr_evt = 1'b0; eng_data_evt = 1'b0;
    endtask

    // R1: reset state of outputs and registers
    task automatic t_reset();
        chk_out(0, 0, 0, 0, 0, "R1");
        for (int a = 0; a < 4; a++) begin
            rd(ADDR_W'(a), rd_val);
            chk(rd_val, 0, "R1 register read");
        end
    endtask

    // R2 R8: readback masks and ignored command with nothing pending
    task automatic t_readback();
        wr(A_CTRLA, 8'hFF);
        rd(A_CTRLA, rd_val); chk(rd_val, 8'h01, "R2 control A readback");
        wr(A_CTRLB, 8'hFF);
        chk_out(0, 0, 0, 0, 0, "R8 command with nothing pending");
        rd(A_CTRLB, rd_val); chk(rd_val, 8'h04, "R2 control B readback");
        wr(A_CTRLA, 8'h00);
        wr(A_CTRLB, 8'h00);
        rd(A_CTRLB, rd_val); chk(rd_val, 8'h00, "R2 control B cleared");
    endtask

    // R3 R10: event capture and plain data read without smart mode
    task automatic t_event();
        evt(1, 1, 8'hA5);
        chk(stretch_hold, 1, "R3 hold after address event");
        rd(A_STAT, rd_val); chk(rd_val, 8'h06, "R3 status address dir1");
        rd(A_DATA, rd_val); chk(rd_val, 8'hA5, "R3 data byte");
        chk_out(1, 0, 0, 0, 0, "R10 data read without smart");
        wr(A_CTRLB, 8'h03);
        @(negedge clk);
        evt(0, 0, 8'h5A);
        rd(A_STAT, rd_val); chk(rd_val, 8'h01, "R3 status data dir0");
        wr(A_CTRLB, 8'h03);
        @(negedge clk);
    endtask

    // One combination: event kind, direction, trigger path, command, select.
    task automatic run_case(input int cmd, input bit dir, input bit is_addr,
                            input bit smart, input bit sel);
        bit rx, valid, e_ack, e_nack, e_wait;
        string req;
        rx     = is_addr || !dir;
        valid  = smart ? rx : (cmd >= 2);
        e_ack  = valid && rx;
        e_nack = e_ack && sel;
        e_wait = !smart && valid && (cmd == 2);
        if (smart) req = rx ? "R9" : "R10";
        else if (cmd < 2) req = "R8";
        else if (cmd == 2) req = rx ? "R4" : "R5";
        else req = rx ? "R6" : "R7";
        wr(A_CTRLA, {7'd0, smart});
        if (smart) wr(A_CTRLB, {5'd0, sel, 2'b00});
        evt(is_addr, dir, 8'h3C);
        if (smart) rd(A_DATA, rd_val);
        else wr(A_CTRLB, {5'd0, sel, 2'(cmd)});
        chk_out(!valid, valid, e_ack, e_nack, e_wait, req);
        @(negedge clk);
        chk_out(!valid, 0, 0, 0, 0, {req, " pulse width"});
        if (!valid) begin
            rd(A_STAT, rd_val);
            chk(rd_val, is_addr ? {5'd0, dir, 2'b10} : {5'd0, dir, 2'b01},
                {req, " flags kept"});
            wr(A_CTRLB, 8'h03);
            @(negedge clk);
        end
    endtask

    task automatic t_sweep();
        for (int c = 0; c < 4; c++)
            for (int d = 0; d < 2; d++)
                for (int k = 0; k < 2; k++)
                    for (int s = 0; s < 2; s++)
                        for (int a = 0; a < 2; a++)
                            run_case(c, d[0], k[0], s[0], a[0]);
        wr(A_CTRLA, 8'h00);
    endtask

    // R11: a new event in the cycle of a release stays pending
    task automatic t_overlap();
        evt(1, 0, 8'h11);
        reg_wr_en = 1'b1; reg_addr = A_CTRLB; reg_wdata = 8'h02;
        eng_data_evt = 1'b1; eng_dir = 1'b0; eng_byte = 8'h77;
        @(negedge clk);
        reg_wr_en = 1'b0; eng_data_evt = 1'b0;
        chk_out(1, 1, 1, 0, 1, "R11 release with overlapping event");
        rd(A_STAT, rd_val); chk(rd_val, 8'h01, "R11 new data flag pending");
        rd(A_DATA, rd_val); chk(rd_val, 8'h77, "R11 new byte latched");
        wr(A_CTRLB, 8'h07);
        chk_out(0, 1, 1, 1, 0, "R6 release of overlapped event");
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_event();
        t_sweep();
        t_overlap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired (all requirements): actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule